// File: doc/BRIEF.md
# PMBus Host Register Bank

This block is the processor-facing register bank of a PMBus/SMBus bus master. Software reaches it over a WISHBONE Classic slave port that has an 8-bit data path and a 3-bit address. Through that port software sets the SCL prescale value, enables the core and its interrupt, loads the byte to transmit, reads the byte received, issues commands and reads status. The block passes the prescale value, the enable and the pending command bits to a byte-level sequencer. From the sequencer it takes completion, acknowledge, busy, arbitration-loss and received-data signals.

The block also does the bus housekeeping that PMBus adds to plain I2C. It watches SCL for a stuck-low condition and watches SCL and SDA together for a long idle-high period. The limits are 25 ms and 50 ms, converted to clock cycles from a clock-frequency parameter. It brings the active-low alert line into a status bit through a two-stage synchronizer. It drives an active-low control pin from a command bit. Byte and bit sequencing and the open-drain pin drivers belong to other blocks.

Top module: `pmb_host_regs`

## Requirements
- R1: Every access is acknowledged with `bus_ack_o` high for exactly one cycle, in the cycle after `bus_cyc_i` and `bus_stb_i` are first seen high. `bus_ack_o` is never high in two consecutive cycles, even when the request is held continuously.
- R2: Address map: 0 is the prescale low byte, 1 is the prescale high byte, 2 is control (bit 7 core enable, bit 6 interrupt enable, bits 5:0 read as 0), 3 is transmit on write and receive on read, and 4 is command on write and status on read. Addresses 5 to 7 read as 0 and ignore writes. The receive register loads `rxd_i` when `xfer_done_i` is high. Reset values: prescale 0xFFFF, control 0x00, status 0x00 with idle inputs.
- R3: The prescale bytes change only on writes made while the core enable bit is 0. `prescale_o` shows {high, low}.
- R4: While core enable is 0, a command write has no effect. No command output rises, the control pin does not change, and neither the interrupt flag nor the timeout flags are cleared.
- R5: Command bits 7..3 (start, stop, read, write, NACK-when-receiving) appear on `sta_o`, `sto_o`, `rd_o`, `wr_o`, `nack_o` after a write while enabled. They are held until `xfer_done_i` or `arb_lost_i` is high, which clears them; a command write in that same cycle wins. Status bit 1 (transfer in progress) is high while read or write is pending.
- R6: Status bit 0 (interrupt flag) sets when `xfer_done_i` or `arb_lost_i` is high. It clears on a command write with bit 0 set; a new set in the same cycle wins. `irq_o` equals the flag ANDed with the interrupt enable, delayed by one register.
- R7: Status bit 7 follows `slave_nack_i` and bit 6 follows `bus_busy_i`, each one cycle late. Bit 5 sets on `arb_lost_i` and stays set until a command write with bit 7 (start) set.
- R8: Status bit 2 sets once `scl_i` has been low for LOW_MS milliseconds of consecutive clock cycles (CLK_HZ·LOW_MS/1000). Any cycle with `scl_i` high restarts the count. The bit stays set until a command write with bit 2 set.
- R9: Status bit 3 sets once `scl_i` and `sda_i` have both been high for IDLE_MS milliseconds of consecutive cycles. It restarts the same way as R8 and clears with command bit 2.
- R10: Status bit 4 reads the inverse of `alert_n_i` after two synchronizing flip-flops.
- R11: `ctl_n_o` is low exactly when the last accepted command write had bit 1 set. It is high after reset.
- R12: Either the synchronous `srst_i` or the asynchronous `arst_i` (active at level ARST_LVL, taking effect without a clock edge) returns all registers to their reset values.
- R13: `txd_o` holds the last byte written to address 3, whatever the enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| srst_i | input | 1 | Synchronous reset, active high |
| arst_i | input | 1 | Asynchronous reset, active at ARST_LVL |
| bus_adr_i | input | 3 | Register address |
| bus_dat_i | input | 8 | Write data |
| bus_dat_o | output | 8 | Registered read data |
| bus_we_i | input | 1 | Write enable |
| bus_stb_i | input | 1 | Strobe |
| bus_cyc_i | input | 1 | Cycle valid |
| bus_ack_o | output | 1 | Access acknowledge |
| irq_o | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| alert_n_i | input | 1 | Alert line, active low |
| ctl_n_o | output | 1 | Control pin, active low |
| prescale_o | output | 16 | SCL prescale value |
| core_en_o | output | 1 | Core enable |
| sta_o | output | 1 | Pending start command |
| sto_o | output | 1 | Pending stop command |
| rd_o | output | 1 | Pending read command |
| wr_o | output | 1 | Pending write command |
| nack_o | output | 1 | Send NACK when receiving |
| txd_o | output | 8 | Byte to transmit |
| xfer_done_i | input | 1 | Byte transfer complete |
| slave_nack_i | input | 1 | Slave did not acknowledge |
| bus_busy_i | input | 1 | Bus busy |
| arb_lost_i | input | 1 | Arbitration lost |
| rxd_i | input | 8 | Received byte |

## Verification
The command path is tried with the core enabled and with it disabled, using the same command bytes, so that a missing enable gate shows up on the strobe outputs and the control pin. The timeout monitors get line-low and both-high runs one cycle shorter than the limit and exactly at the limit. This tells an off-by-one counter apart from a correct one, and a later disabled clear tells sticky bits apart from self-clearing ones. Completion and arbitration-loss pulses are applied with the interrupt enable on and off, and interrupt-acknowledge writes are timed against them. This separates the flag, its gating onto `irq_o` and the register delay. The alert is read in back-to-back accesses to pin down the two-stage synchronizer delay.

// File: rtl/pmb_regs_pkg.sv
package pmb_regs_pkg;

  // register addresses (decoded by software drivers)
  localparam logic [2:0] ADR_PRE_LO = 3'd0;
  localparam logic [2:0] ADR_PRE_HI = 3'd1;
  localparam logic [2:0] ADR_CTRL   = 3'd2;
  localparam logic [2:0] ADR_DATA   = 3'd3;
  localparam logic [2:0] ADR_CMDSTS = 3'd4;

  // command bit positions
  localparam int CB_STA  = 7;
  localparam int CB_STO  = 6;
  localparam int CB_RD   = 5;
  localparam int CB_WR   = 4;
  localparam int CB_NACK = 3;
  localparam int CB_CLRT = 2;
  localparam int CB_CTL  = 1;
  localparam int CB_IACK = 0;

  // timeout monitor slots
  localparam int TMO_LOW  = 0;
  localparam int TMO_IDLE = 1;
  localparam int TMO_N    = 2;

  typedef struct packed {
    logic sta;
    logic sto;
    logic rd;
    logic wr;
    logic nack;
  } pend_cmd_t;

  // milliseconds to clock cycles, never below one
  function automatic int unsigned ms_to_cycles(input longint unsigned hz,
                                               input longint unsigned ms);
    longint unsigned c;
    c = (hz * ms) / 64'd1000;
    if (c < 64'd1) c = 64'd1;
    return int'(c);
  endfunction

  // status byte assembly
  function automatic logic [7:0] pack_status(input logic nack, input logic busy,
                                             input logic al, input logic alert,
                                             input logic idle_t, input logic low_t,
                                             input logic tip, input logic irq);
    return {nack, busy, al, alert, idle_t, low_t, tip, irq};
  endfunction

endpackage

// File: rtl/pmb_bus_port.sv
module pmb_bus_port (
  input  logic clk_i,
  input  logic arst_act,
  input  logic srst_i,
  input  logic cyc_i,
  input  logic stb_i,
  input  logic we_i,
  output logic ack_o,
  output logic acc_wr,
  output logic acc_rd
);
  logic acc;

  // a request is taken once; the acknowledge cycle blocks a second take
  assign acc    = cyc_i && stb_i && !ack_o;
  assign acc_wr = acc && we_i;
  assign acc_rd = acc && !we_i;

  always_ff @(posedge clk_i or posedge arst_act) begin
    if (arst_act || srst_i) ack_o <= 1'b0;
    else                    ack_o <= acc;
  end
endmodule

// File: rtl/pmb_sync2.sv
module pmb_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic arst_act,
  input  logic srst_i,
  input  logic d_i,
  output logic q_o
);
  logic s1;

  always_ff @(posedge clk_i or posedge arst_act) begin
    if (arst_act || srst_i) begin
      s1  <= RST_VAL;
      q_o <= RST_VAL;
    end else begin
      s1  <= d_i;
      q_o <= s1;
    end
  end
endmodule

// File: rtl/pmb_line_timeout.sv
module pmb_line_timeout #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic arst_act,
  input  logic srst_i,
  input  logic cond_i,
  input  logic clr_i,
  output logic flag_o
);
  localparam int unsigned LIM = (LIMIT < 2) ? 2 : LIMIT;
  localparam int CW = $clog2(LIM);
  localparam logic [CW-1:0] LAST = CW'(LIM - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == LAST);

  always_ff @(posedge clk_i or posedge arst_act) begin
    if (arst_act || srst_i) begin
      cnt    <= '0;
      flag_o <= 1'b0;
    end else if (clr_i) begin
      cnt    <= '0;
      flag_o <= 1'b0;
    end else if (!cond_i) begin
      cnt    <= '0;
    end else if (at_last) begin
      flag_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pmb_host_regs.sv
module pmb_host_regs
  import pmb_regs_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned     LOW_MS   = 25,
  parameter int unsigned     IDLE_MS  = 50,
  parameter logic            ARST_LVL = 1'b0,
  parameter logic [15:0]     PRE_RST  = 16'hFFFF
) (
  input  logic        clk_i,
  input  logic        srst_i,
  input  logic        arst_i,
  input  logic [2:0]  bus_adr_i,
  input  logic [7:0]  bus_dat_i,
  output logic [7:0]  bus_dat_o,
  input  logic        bus_we_i,
  input  logic        bus_stb_i,
  input  logic        bus_cyc_i,
  output logic        bus_ack_o,
  output logic        irq_o,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        alert_n_i,
  output logic        ctl_n_o,
  output logic [15:0] prescale_o,
  output logic        core_en_o,
  output logic        sta_o,
  output logic        sto_o,
  output logic        rd_o,
  output logic        wr_o,
  output logic        nack_o,
  output logic [7:0]  txd_o,
  input  logic        xfer_done_i,
  input  logic        slave_nack_i,
  input  logic        bus_busy_i,
  input  logic        arb_lost_i,
  input  logic [7:0]  rxd_i
);
  localparam int unsigned LOW_LIM  = ms_to_cycles(CLK_HZ, 64'(LOW_MS));
  localparam int unsigned IDLE_LIM = ms_to_cycles(CLK_HZ, 64'(IDLE_MS));

  // named internal events
  logic        arst_act, rst_any;
  logic        acc_wr, acc_rd;
  logic        cmd_wr_ev, clr_tmo, iack_ev, end_ev;
  logic [TMO_N-1:0] tmo_cond, tmo_flag;
  logic        alert_s;

  // register state
  logic [7:0]  pre_lo, pre_hi, ctrl_q, rx_q, tx_q;
  pend_cmd_t   pend;
  logic        ctl_bit, al_q, irq_q, nack_q, busy_q;
  logic [7:0]  sts_byte, rd_mux;

  assign arst_act = (arst_i == ARST_LVL);
  assign rst_any  = arst_act || srst_i;

  pmb_bus_port u_port (
    .clk_i    (clk_i),
    .arst_act (arst_act),
    .srst_i   (srst_i),
    .cyc_i    (bus_cyc_i),
    .stb_i    (bus_stb_i),
    .we_i     (bus_we_i),
    .ack_o    (bus_ack_o),
    .acc_wr   (acc_wr),
    .acc_rd   (acc_rd)
  );

  pmb_sync2 #(.RST_VAL(1'b0)) u_alert_sync (
    .clk_i    (clk_i),
    .arst_act (arst_act),
    .srst_i   (srst_i),
    .d_i      (!alert_n_i),
    .q_o      (alert_s)
  );

  // command decode: accepted only while enabled
  assign cmd_wr_ev = acc_wr && (bus_adr_i == ADR_CMDSTS) && ctrl_q[7];
  assign clr_tmo   = cmd_wr_ev && bus_dat_i[CB_CLRT];
  assign iack_ev   = cmd_wr_ev && bus_dat_i[CB_IACK];
  assign end_ev    = xfer_done_i || arb_lost_i;

  assign tmo_cond[TMO_LOW]  = !scl_i;
  assign tmo_cond[TMO_IDLE] = scl_i && sda_i;

  for (genvar g = 0; g < TMO_N; g++) begin : g_tmo
    pmb_line_timeout #(
      .LIMIT((g == TMO_LOW) ? LOW_LIM : IDLE_LIM)
    ) u_mon (
      .clk_i    (clk_i),
      .arst_act (arst_act),
      .srst_i   (srst_i),
      .cond_i   (tmo_cond[g]),
      .clr_i    (clr_tmo),
      .flag_o   (tmo_flag[g])
    );
  end

  assign sts_byte = pack_status(nack_q, busy_q, al_q, alert_s,
                                tmo_flag[TMO_IDLE], tmo_flag[TMO_LOW],
                                pend.rd || pend.wr, irq_q);

  always_comb begin
    case (bus_adr_i)
      ADR_PRE_LO: rd_mux = pre_lo;
      ADR_PRE_HI: rd_mux = pre_hi;
      ADR_CTRL:   rd_mux = {ctrl_q[7:6], 6'b0};
      ADR_DATA:   rd_mux = rx_q;
      ADR_CMDSTS: rd_mux = sts_byte;
      default:    rd_mux = 8'h00;
    endcase
  end

  // host-written registers
  always_ff @(posedge clk_i or posedge arst_act) begin
    if (arst_act || srst_i) begin
      pre_lo <= PRE_RST[7:0];
      pre_hi <= PRE_RST[15:8];
      ctrl_q <= 8'h00;
      tx_q   <= 8'h00;
    end else if (acc_wr) begin
      case (bus_adr_i)
        ADR_PRE_LO: if (!ctrl_q[7]) pre_lo <= bus_dat_i;
        ADR_PRE_HI: if (!ctrl_q[7]) pre_hi <= bus_dat_i;
        ADR_CTRL:   ctrl_q <= {bus_dat_i[7:6], 6'b0};
        ADR_DATA:   tx_q   <= bus_dat_i;
        default:    ;
      endcase
    end
  end

  // command and status state
  always_ff @(posedge clk_i or posedge arst_act) begin
    if (arst_act || srst_i) begin
      pend    <= '0;
      ctl_bit <= 1'b0;
      al_q    <= 1'b0;
      irq_q   <= 1'b0;
      nack_q  <= 1'b0;
      busy_q  <= 1'b0;
      rx_q    <= 8'h00;
      irq_o   <= 1'b0;
    end else begin
      if (cmd_wr_ev) begin
        pend    <= pend_cmd_t'(bus_dat_i[CB_STA:CB_NACK]);
        ctl_bit <= bus_dat_i[CB_CTL];
      end else if (end_ev) begin
        pend    <= '0;
      end
      al_q   <= arb_lost_i || (al_q && !(cmd_wr_ev && bus_dat_i[CB_STA]));
      irq_q  <= end_ev || (irq_q && !iack_ev);
      nack_q <= slave_nack_i;
      busy_q <= bus_busy_i;
      if (xfer_done_i) rx_q <= rxd_i;
      irq_o  <= irq_q && ctrl_q[6];
    end
  end

  always_ff @(posedge clk_i or posedge arst_act) begin
    if (arst_act || srst_i) bus_dat_o <= 8'h00;
    else if (acc_rd)        bus_dat_o <= rd_mux;
  end

  assign prescale_o = {pre_hi, pre_lo};
  assign core_en_o  = ctrl_q[7];
  assign ctl_n_o    = !ctl_bit;
  assign txd_o      = tx_q;
  assign sta_o      = pend.sta;
  assign sto_o      = pend.sto;
  assign rd_o       = pend.rd;
  assign wr_o       = pend.wr;
  assign nack_o     = pend.nack;

endmodule

// File: rtl/pmb_host_regs_chk.sv
module pmb_host_regs_chk (
  input logic        clk,
  input logic        rst_any,
  input logic        cyc,
  input logic        stb,
  input logic        ack,
  input logic        core_en,
  input logic [15:0] prescale,
  input logic        sta,
  input logic        sto,
  input logic        rd,
  input logic        wr,
  input logic        end_ev,
  input logic        cmd_wr_ev,
  input logic        scl,
  input logic        sda,
  input logic        low_flag,
  input logic        idle_flag,
  input logic        irq_flag,
  input logic        irq
);
  // R1
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst_any)
    ack |=> !ack);
  // R1
  ack_reply_chk: assert property (@(posedge clk) disable iff (rst_any)
    (cyc && stb && !ack) |=> ack);
  // R3
  prescale_lock_chk: assert property (@(posedge clk) disable iff (rst_any)
    core_en |=> $stable(prescale));
  // R4
  cmd_idle_chk: assert property (@(posedge clk) disable iff (rst_any)
    (!core_en && !sta && !sto && !rd && !wr) |=> !(sta || sto || rd || wr));
  // R5
  cmd_done_chk: assert property (@(posedge clk) disable iff (rst_any)
    (end_ev && !cmd_wr_ev) |=> !(sta || sto || rd || wr));
  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (rst_any)
    irq |-> $past(irq_flag));
  // R8
  low_rise_chk: assert property (@(posedge clk) disable iff (rst_any)
    $rose(low_flag) |-> $past(!scl));
  // R9
  idle_rise_chk: assert property (@(posedge clk) disable iff (rst_any)
    $rose(idle_flag) |-> $past(scl && sda));
endmodule

bind pmb_host_regs pmb_host_regs_chk u_chk (
  .clk       (clk_i),
  .rst_any   (rst_any),
  .cyc       (bus_cyc_i),
  .stb       (bus_stb_i),
  .ack       (bus_ack_o),
  .core_en   (core_en_o),
  .prescale  (prescale_o),
  .sta       (sta_o),
  .sto       (sto_o),
  .rd        (rd_o),
  .wr        (wr_o),
  .end_ev    (end_ev),
  .cmd_wr_ev (cmd_wr_ev),
  .scl       (scl_i),
  .sda       (sda_i),
  .low_flag  (tmo_flag[0]),
  .idle_flag (tmo_flag[1]),
  .irq_flag  (irq_q),
  .irq       (irq_o)
);

// File: tb/test_pmb_host_regs.sv
`timescale 1ns/1ps
module test_pmb_host_regs;
  // 1 kHz nominal clock: 25 ms -> 25 cycles, 50 ms -> 50 cycles
  localparam int LOWC  = 25;
  localparam int IDLEC = 50;

  logic clk = 1'b0;
  logic srst = 1'b1, arst = 1'b0;
  logic [2:0] adr = '0;
  logic [7:0] wdat = '0;
  logic [7:0] rdat;
  logic we = 1'b0, stb = 1'b0, cyc = 1'b0, ack;
  logic irq, ctl_n, core_en, sta, sto, rd, wr, nack;
  logic scl = 1'b1, sda = 1'b0, alert_n = 1'b1;
  logic [15:0] pre;
  logic [7:0] txd;
  logic done = 1'b0, snack = 1'b0, busy = 1'b0, arbl = 1'b0;
  logic [7:0] rxd = '0;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pmb_host_regs #(.CLK_HZ(1000), .LOW_MS(25), .IDLE_MS(50), .ARST_LVL(1'b0))
  i_pmb_host_regs (
    .clk_i(clk), .srst_i(srst), .arst_i(arst), .bus_adr_i(adr), .bus_dat_i(wdat),
    .bus_dat_o(rdat), .bus_we_i(we), .bus_stb_i(stb), .bus_cyc_i(cyc),
    .bus_ack_o(ack), .irq_o(irq), .scl_i(scl), .sda_i(sda), .alert_n_i(alert_n),
    .ctl_n_o(ctl_n), .prescale_o(pre), .core_en_o(core_en), .sta_o(sta),
    .sto_o(sto), .rd_o(rd), .wr_o(wr), .nack_o(nack), .txd_o(txd),
    .xfer_done_i(done), .slave_nack_i(snack), .bus_busy_i(busy),
    .arb_lost_i(arbl), .rxd_i(rxd)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // call at a negedge; returns at a negedge
  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    adr = a; wdat = d; we = 1'b1; cyc = 1'b1; stb = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 write ack", 16'(ack), 16'd1);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    adr = a; we = 1'b0; cyc = 1'b1; stb = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 read ack", 16'(ack), 16'd1);
    d = rdat;
    cyc = 1'b0; stb = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_rd(3'd0, d); chk("R2 reset prescale lo", 16'(d), 16'hFF);
    bus_rd(3'd1, d); chk("R2 reset prescale hi", 16'(d), 16'hFF);
    bus_rd(3'd2, d); chk("R2 reset control", 16'(d), 16'h00);
    bus_rd(3'd4, d); chk("R2 reset status", 16'(d), 16'h00);
    chk("R11 reset ctl_n", 16'(ctl_n), 16'd1);
    chk("R12 reset irq", 16'(irq), 16'd0);
  endtask

  task automatic t_prescale();
    logic [7:0] d;
    bus_wr(3'd0, 8'h34); bus_wr(3'd1, 8'h12);
    chk("R3 prescale while disabled", pre, 16'h1234);
    bus_wr(3'd2, 8'hBF);
    bus_rd(3'd2, d); chk("R2 control reserved bits read 0", 16'(d), 16'h80);
    bus_wr(3'd0, 8'h99); bus_wr(3'd1, 8'h77);
    chk("R3 prescale locked while enabled", pre, 16'h1234);
    bus_rd(3'd0, d); chk("R3 prescale lo readback", 16'(d), 16'h34);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    bus_wr(3'd5, 8'h77);
    bus_rd(3'd5, d); chk("R2 unmapped reads 0", 16'(d), 16'h00);
    bus_rd(3'd2, d); chk("R2 unmapped write ignored", 16'(d), 16'h80);
  endtask

  task automatic t_ack_hold();
    adr = 3'd2; we = 1'b0; cyc = 1'b1; stb = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R1 held request ack pattern", 16'(ack), 16'(i % 2 == 0));
    end
    cyc = 1'b0; stb = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_disabled_cmd();
    bus_wr(3'd2, 8'h00);
    bus_wr(3'd4, 8'hFA);
    chk("R4 no command while disabled", {11'd0, sta, sto, rd, wr, nack}, 16'd0);
    chk("R4 ctl_n unchanged while disabled", 16'(ctl_n), 16'd1);
  endtask

  task automatic t_cmd();
    logic [7:0] d;
    bus_wr(3'd2, 8'h80);
    bus_wr(3'd4, 8'h98);
    chk("R5 command outputs", {11'd0, sta, sto, rd, wr, nack}, 16'b10011);
    bus_rd(3'd4, d); chk("R5 transfer in progress", 16'(d[1]), 16'd1);
    snack = 1'b1; rxd = 8'h5A;
    pulse(done);
    chk("R5 commands cleared by done", {11'd0, sta, sto, rd, wr, nack}, 16'd0);
    bus_rd(3'd4, d); chk("R7 status after done", 16'(d), 16'h81);
    bus_rd(3'd3, d); chk("R2 receive register", 16'(d), 16'h5A);
    chk("R6 irq gated by enable", 16'(irq), 16'd0);
    snack = 1'b0;
  endtask

  task automatic t_irq();
    bus_wr(3'd2, 8'hC0);
    chk("R6 irq after enable", 16'(irq), 16'd1);
    bus_wr(3'd4, 8'h01);
    chk("R6 irq cleared by IACK", 16'(irq), 16'd0);
    pulse(done);
    chk("R6 irq one register late", 16'(irq), 16'd0);
    @(negedge clk);
    chk("R6 irq raised", 16'(irq), 16'd1);
    bus_wr(3'd4, 8'h01);
  endtask

  task automatic t_al();
    logic [7:0] d;
    busy = 1'b1;
    pulse(arbl);
    bus_rd(3'd4, d); chk("R7 arbitration lost status", 16'(d), 16'h61);
    bus_wr(3'd4, 8'h81);
    chk("R5 start pending", 16'(sta), 16'd1);
    bus_rd(3'd4, d); chk("R7 AL cleared by start", 16'(d), 16'h40);
    pulse(arbl);
    chk("R5 cleared by arbitration loss", 16'(sta), 16'd0);
    bus_wr(3'd4, 8'h81);
    busy = 1'b0;
    pulse(done);
    bus_wr(3'd4, 8'h01);
  endtask

  task automatic t_control();
    bus_wr(3'd4, 8'h02);
    chk("R11 control pin low", 16'(ctl_n), 16'd0);
    bus_wr(3'd4, 8'h00);
    chk("R11 control pin high", 16'(ctl_n), 16'd1);
  endtask

  task automatic t_low_tmo();
    logic [7:0] d;
    scl = 1'b0; repeat (LOWC - 1) @(posedge clk); @(negedge clk); scl = 1'b1;
    bus_rd(3'd4, d); chk("R8 low one short", 16'(d[2]), 16'd0);
    scl = 1'b0; repeat (LOWC) @(posedge clk); @(negedge clk); scl = 1'b1;
    bus_rd(3'd4, d); chk("R8 low at limit", 16'(d[2]), 16'd1);
    repeat (5) @(negedge clk);
    bus_rd(3'd4, d); chk("R8 low flag sticky", 16'(d[2]), 16'd1);
    bus_wr(3'd2, 8'h00); bus_wr(3'd4, 8'h04);
    bus_rd(3'd4, d); chk("R4 clear ignored while disabled", 16'(d[2]), 16'd1);
    bus_wr(3'd2, 8'h80); bus_wr(3'd4, 8'h04);
    bus_rd(3'd4, d); chk("R8 low flag cleared", 16'(d[2]), 16'd0);
  endtask

  task automatic t_idle_tmo();
    logic [7:0] d;
    sda = 1'b1; repeat (IDLEC - 1) @(posedge clk); @(negedge clk); sda = 1'b0;
    bus_rd(3'd4, d); chk("R9 idle one short", 16'(d[3]), 16'd0);
    sda = 1'b1; repeat (IDLEC) @(posedge clk); @(negedge clk); sda = 1'b0;
    bus_rd(3'd4, d); chk("R9 idle at limit", 16'(d[3]), 16'd1);
    bus_wr(3'd4, 8'h04);
    bus_rd(3'd4, d); chk("R9 idle flag cleared", 16'(d[3]), 16'd0);
  endtask

  task automatic t_alert();
    logic [7:0] d;
    alert_n = 1'b0;
    bus_rd(3'd4, d); chk("R10 alert not yet through", 16'(d[4]), 16'd0);
    bus_rd(3'd4, d); chk("R10 alert after sync", 16'(d[4]), 16'd1);
    alert_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd(3'd4, d); chk("R10 alert released", 16'(d[4]), 16'd0);
  endtask

  task automatic t_tx();
    bus_wr(3'd3, 8'hC3);
    chk("R13 transmit register enabled", 16'(txd), 16'hC3);
    bus_wr(3'd2, 8'h00);
    bus_wr(3'd3, 8'h3C);
    chk("R13 transmit register disabled", 16'(txd), 16'h3C);
  endtask

  task automatic t_arst();
    bus_wr(3'd0, 8'h11);
    chk("R3 prescale write", pre, 16'h1211);
    bus_wr(3'd4, 8'h00);
    bus_wr(3'd2, 8'h80); bus_wr(3'd4, 8'h02); bus_wr(3'd2, 8'h00);
    chk("R11 pin low before reset", 16'(ctl_n), 16'd0);
    #1 arst = 1'b0; #0.5;
    chk("R12 async reset prescale", pre, 16'hFFFF);
    chk("R12 async reset ctl_n", 16'(ctl_n), 16'd1);
    arst = 1'b1;
    @(negedge clk);
    bus_wr(3'd2, 8'h80);
    srst = 1'b1; @(negedge clk); srst = 1'b0;
    chk("R12 sync reset enable", 16'(core_en), 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    arst = 1'b1;
    @(negedge clk); srst = 1'b0;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_unmapped();
    t_ack_hold();
    t_disabled_cmd();
    t_cmd();
    t_irq();
    t_al();
    t_control();
    t_low_tmo();
    t_idle_tmo();
    t_alert();
    t_tx();
    t_arst();
    finish_run();
  end
endmodule